// File: doc/BRIEF.md
# ARINC 429 Serial Word Transmitter

This block turns 32-bit words from a host into the return-to-zero bipolar signalling used on an ARINC 429 line pair. The host writes each word through a 16-bit parallel port in two halves, each half with its own active-low strobe. The second strobe completes the word and pushes it into an eight-entry first-in, first-out queue. A serializer takes words from the head of the queue and drives them onto two digital line signals. The analog line driver is outside the block, and it converts these signals to the HI, NULL and LO line levels.

A configuration register is loaded from the same 16-bit port by a third active-low strobe. It selects the bit rate (fast, or eight times slower) and whether the transmitter forces odd parity into the last bit. Nothing is sent until this register has been written once after reset. An enable input lets the host stop new words from starting while it refills the queue. An empty flag reports when the queue has drained. A sticky overflow flag records a word that was written while the queue was full.

Top module: `a429_tx`

## Requirements
- R1: While reset is held and just after reset is released, both line outputs are 0, `q_empty` is 1 and `q_overflow` is 0.
- R2: No bit is driven on the line until the configuration strobe `cfg_ld_n` has been seen low once after reset, even when words are queued and `tx_en` is 1.
- R3: Each strobe acts once, on the first clock at which it is sampled low after being high. A `lo_ld_n` strobe stores `wdata` as bits 1–16 of the word being built (bit 1 = `wdata[0]`). A `hi_ld_n` strobe supplies bits 17–32 (bit 17 = `wdata[0]`) and queues the complete word. On the line, bit 1 is sent first and bit 32 last.
- R4: Every bit cell is two equal halves. In the first half, `line_a`=1 and `line_b`=0 for a one, or `line_a`=0 and `line_b`=1 for a zero. In the second half, both signals are 0. The two signals are never 1 together.
- R5: The queue holds up to 8 words and sends them in the order in which they were written.
- R6: `q_empty` is 1 when the queue holds no word. It is 0 from the clock after a `hi_ld_n` strobe.
- R7: A `hi_ld_n` strobe while 8 words are queued is ignored: the word is never sent. It sets `q_overflow`, which stays 1 until reset.
- R8: While `tx_en` is 0, no new word begins on the line. Queued words remain queued.
- R9: Configuration bit `wdata[1]`=1 turns parity on: bit 32 is replaced so that the 32 transmitted bits hold an odd number of ones. With `wdata[1]`=0, bit 32 is sent as written.
- R10: Configuration bit `wdata[0]`=0 selects the fast rate, a cell of 2·HALF_FAST clocks. `wdata[0]`=1 selects the slow rate, a cell RATE_RATIO times longer. The rate in force when a word starts applies to the whole word.
- R11: Between the end of one word's last bit cell and the start of the next word, the line stays null for at least 4 bit times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wdata | input | 16 | Parallel data for word halves and configuration |
| cfg_ld_n | input | 1 | Active-low configuration load strobe |
| lo_ld_n | input | 1 | Active-low strobe for word bits 1–16 |
| hi_ld_n | input | 1 | Active-low strobe for word bits 17–32; queues the word |
| tx_en | input | 1 | Allows a new word to start when 1 |
| q_empty | output | 1 | Queue holds no word |
| q_overflow | output | 1 | Sticky: a word was written into a full queue |
| line_a | output | 1 | HI drive request for the line driver |
| line_b | output | 1 | LO drive request for the line driver |

## Verification
The assertions take the host port to be synchronous to `clk`. They also take the strobes to be asserted one at a time, and each strobe to return high between uses, since edge detection on these strobes defines when a load happens. The bench drives every input on the falling clock edge. It holds each strobe low for exactly one cycle, never asserts two strobes at once, and writes configuration only while the queue is empty or while no new word can start. As a result, rate and parity changes always take effect at a word boundary.

// File: rtl/a429_pkg.sv
package a429_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int CFG_RATE = 0;
  localparam int CFG_PAR  = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } ser_state_e;
endpackage

// File: rtl/a429_fifo.sv
module a429_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, wptr_d, rptr_q, rptr_d;

  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign dout  = mem[rptr_q[AW-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (push && !full) wptr_d = wptr_q + 1'b1;
    if (pop && !empty) rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr_q[AW-1:0]] <= din;
  end
endmodule

// File: rtl/a429_loader.sv
module a429_loader
  import a429_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] wdata,
  input  logic              cfg_ld_n,
  input  logic              lo_ld_n,
  input  logic              hi_ld_n,
  input  logic              q_full,
  output logic              push,
  output logic [WORD_W-1:0] push_word,
  output logic              cfg_valid,
  output logic              rate_slow,
  output logic              par_en,
  output logic              overflow
);
  logic              cfg_p_q, lo_p_q, hi_p_q;
  logic              cfg_stb, lo_stb, hi_stb;
  logic [HALF_W-1:0] lo_q, lo_d;
  logic              vld_q, vld_d, rate_q, rate_d, par_q, par_d, ovf_q, ovf_d;

  assign cfg_stb = cfg_p_q && !cfg_ld_n;
  assign lo_stb  = lo_p_q  && !lo_ld_n;
  assign hi_stb  = hi_p_q  && !hi_ld_n;

  assign push      = hi_stb && !q_full;
  assign push_word = {wdata, lo_q};
  assign cfg_valid = vld_q;
  assign rate_slow = rate_q;
  assign par_en    = par_q;
  assign overflow  = ovf_q;

  always_comb begin
    lo_d   = lo_q;
    vld_d  = vld_q;
    rate_d = rate_q;
    par_d  = par_q;
    ovf_d  = ovf_q;
    if (lo_stb) lo_d = wdata;
    if (cfg_stb) begin
      vld_d  = 1'b1;
      rate_d = wdata[CFG_RATE];
      par_d  = wdata[CFG_PAR];
    end
    if (hi_stb && q_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_p_q <= 1'b1;
      lo_p_q  <= 1'b1;
      hi_p_q  <= 1'b1;
      lo_q    <= '0;
      vld_q   <= 1'b0;
      rate_q  <= 1'b0;
      par_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      cfg_p_q <= cfg_ld_n;
      lo_p_q  <= lo_ld_n;
      hi_p_q  <= hi_ld_n;
      lo_q    <= lo_d;
      vld_q   <= vld_d;
      rate_q  <= rate_d;
      par_q   <= par_d;
      ovf_q   <= ovf_d;
    end
  end
endmodule

// File: rtl/a429_ser.sv
module a429_ser
  import a429_pkg::*;
#(
  parameter int HALF_FAST  = 4,
  parameter int RATE_RATIO = 8,
  parameter int GAP_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              tx_en,
  input  logic              rate_slow,
  input  logic              par_en,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] word,
  output logic              pop,
  output logic              line_a,
  output logic              line_b
);
  localparam int HALF_SLOW = HALF_FAST * RATE_RATIO;
  localparam int CW        = $clog2(HALF_SLOW + 1);
  localparam int GW        = $clog2(2 * GAP_BITS + 1);
  localparam int IW        = $clog2(WORD_W);
  localparam logic [CW-1:0] FAST_LD = CW'(HALF_FAST - 1);
  localparam logic [CW-1:0] SLOW_LD = CW'(HALF_SLOW - 1);
  localparam logic [GW-1:0] GAP_LD  = GW'(2 * GAP_BITS - 1);
  localparam logic [IW-1:0] IDX_END = IW'(WORD_W - 1);

  ser_state_e        st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d, run_ld;
  logic [GW-1:0]     gap_q, gap_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              ph_q, ph_d, rate_q, rate_d;

  assign run_ld = rate_q ? SLOW_LD : FAST_LD;
  assign line_a = (st_q == ST_SEND) && !ph_q &&  sh_q[0];
  assign line_b = (st_q == ST_SEND) && !ph_q && !sh_q[0];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    gap_d  = gap_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    ph_d   = ph_q;
    rate_d = rate_q;
    pop    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cfg_valid && tx_en && !fifo_empty) begin
          pop    = 1'b1;
          st_d   = ST_SEND;
          rate_d = rate_slow;
          cnt_d  = rate_slow ? SLOW_LD : FAST_LD;
          ph_d   = 1'b0;
          idx_d  = '0;
          sh_d   = par_en ? {~^word[WORD_W-2:0], word[WORD_W-2:0]} : word;
        end
      end
      ST_SEND: begin
        if (cnt_q == '0) begin
          cnt_d = run_ld;
          if (!ph_q) begin
            ph_d = 1'b1;
          end else begin
            ph_d  = 1'b0;
            sh_d  = sh_q >> 1;
            idx_d = idx_q + 1'b1;
            if (idx_q == IDX_END) begin
              st_d  = ST_GAP;
              gap_d = GAP_LD;
            end
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) begin
          cnt_d = run_ld;
          if (gap_q == '0) st_d = ST_IDLE;
          else             gap_d = gap_q - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      gap_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      ph_q   <= 1'b0;
      rate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      gap_q  <= gap_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      ph_q   <= ph_d;
      rate_q <= rate_d;
    end
  end
endmodule

// File: rtl/a429_tx.sv
module a429_tx
  import a429_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int HALF_FAST  = 4,
  parameter int RATE_RATIO = 8,
  parameter int GAP_BITS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] wdata,
  input  logic        cfg_ld_n,
  input  logic        lo_ld_n,
  input  logic        hi_ld_n,
  input  logic        tx_en,
  output logic        q_empty,
  output logic        q_overflow,
  output logic        line_a,
  output logic        line_b
);
  logic              push, pop, full, cfg_valid, rate_slow, par_en;
  logic [WORD_W-1:0] push_word, head_word;

  a429_loader u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (wdata),
    .cfg_ld_n  (cfg_ld_n),
    .lo_ld_n   (lo_ld_n),
    .hi_ld_n   (hi_ld_n),
    .q_full    (full),
    .push      (push),
    .push_word (push_word),
    .cfg_valid (cfg_valid),
    .rate_slow (rate_slow),
    .par_en    (par_en),
    .overflow  (q_overflow)
  );

  a429_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (push_word),
    .pop   (pop),
    .dout  (head_word),
    .empty (q_empty),
    .full  (full)
  );

  a429_ser #(.HALF_FAST(HALF_FAST), .RATE_RATIO(RATE_RATIO), .GAP_BITS(GAP_BITS)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .tx_en      (tx_en),
    .rate_slow  (rate_slow),
    .par_en     (par_en),
    .fifo_empty (q_empty),
    .word       (head_word),
    .pop        (pop),
    .line_a     (line_a),
    .line_b     (line_b)
  );
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_ld_n,
  input logic hi_ld_n,
  input logic q_empty,
  input logic q_overflow,
  input logic line_a,
  input logic line_b
);
  logic cfg_p_q, hi_p_q, cfg_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_p_q    <= 1'b1;
      hi_p_q     <= 1'b1;
      cfg_seen_q <= 1'b0;
    end else begin
      cfg_p_q <= cfg_ld_n;
      hi_p_q  <= hi_ld_n;
      if (cfg_p_q && !cfg_ld_n) cfg_seen_q <= 1'b1;
    end
  end

  AST_LINE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_a && line_b)); // R4

  AST_QUIET_BEFORE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_seen_q |-> !(line_a || line_b)); // R2

  AST_NOT_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_p_q && !hi_ld_n) |=> !q_empty); // R6

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    q_overflow |=> q_overflow); // R7

  AST_OVERFLOW_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_overflow) |-> !q_empty); // R7
endmodule

bind a429_tx a429_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_ld_n   (cfg_ld_n),
  .hi_ld_n    (hi_ld_n),
  .q_empty    (q_empty),
  .q_overflow (q_overflow),
  .line_a     (line_a),
  .line_b     (line_b)
);

// File: tb/tb_a429_tx.sv
module tb_a429_tx;
  localparam int HF    = 4;
  localparam int RATIO = 8;
  localparam int HS    = HF * RATIO;

  logic        clk, rst_n, cfg_ld_n, lo_ld_n, hi_ld_n, tx_en;
  logic [15:0] wdata;
  logic        q_empty, q_overflow, line_a, line_b;

  int n_chk, n_fail, enc_err, cyc;
  bit done;

  a429_tx #(.DEPTH(8), .HALF_FAST(HF), .RATE_RATIO(RATIO), .GAP_BITS(4)) dut (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .cfg_ld_n(cfg_ld_n),
    .lo_ld_n(lo_ld_n), .hi_ld_n(hi_ld_n), .tx_en(tx_en),
    .q_empty(q_empty), .q_overflow(q_overflow), .line_a(line_a), .line_b(line_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] with_par(input logic [31:0] w);
    return {~^w[30:0], w[30:0]};
  endfunction

  task automatic load_word(input logic [31:0] w);
    @(negedge clk); wdata = w[15:0];  lo_ld_n = 1'b0;
    @(negedge clk); lo_ld_n = 1'b1; wdata = w[31:16]; hi_ld_n = 1'b0;
    @(negedge clk); hi_ld_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk); wdata = v; cfg_ld_n = 1'b0;
    @(negedge clk); cfg_ld_n = 1'b1;
  endtask

  task automatic quiet_for(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line_a || line_b) hits++;
    end
  endtask

  task automatic capture(input int h, output logic [31:0] w, output int gap);
    int c;
    c = 0;
    w = '0;
    while (!(line_a || line_b) && c < 20000) begin
      @(negedge clk);
      c++;
    end
    gap = c;
    for (int k = 0; k < 32; k++) begin
      if (line_a == line_b) enc_err++;
      w[k] = line_a;
      repeat (h) @(negedge clk);
      if (line_a || line_b) enc_err++;
      repeat (h) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check(line_a == 0 && line_b == 0, "R1 line null", {line_a, line_b}, 0);
    check(q_empty == 1, "R1 empty", q_empty, 1);
    check(q_overflow == 0, "R1 overflow", q_overflow, 0);
  endtask

  task automatic t_no_cfg;
    int hits, gap;
    logic [31:0] got;
    tx_en = 1'b1;
    load_word(32'h1234_ABCD);
    check(q_empty == 0, "R6 empty low after load", q_empty, 0);
    quiet_for(200, hits);
    check(hits == 0, "R2 no bits before config", hits, 0);
    write_cfg(16'h0000);
    enc_err = 0;
    capture(HF, got, gap);
    check(got == 32'h1234_ABCD, "R3 word assembly and bit order", got, 32'h1234_ABCD);
    check(enc_err == 0, "R4 RZ encoding", enc_err, 0);
    check(q_empty == 1, "R6 empty after drain", q_empty, 1);
  endtask

  task automatic t_patterns;
    logic [31:0] pat [3];
    logic [31:0] got;
    int gap;
    pat[0] = 32'hC000_0001; pat[1] = 32'h5555_AAAA; pat[2] = 32'h0F0F_F0F0;
    for (int i = 0; i < 3; i++) load_word(pat[i]);
    for (int i = 0; i < 3; i++) begin
      enc_err = 0;
      capture(HF, got, gap);
      check(got == pat[i], "R5 order / R3 data", got, pat[i]);
      check(enc_err == 0, "R4 RZ encoding", enc_err, 0);
      if (i > 0) check(gap >= 8 * HF, "R11 inter-word gap", gap, 8 * HF);
    end
  endtask

  task automatic t_parity;
    logic [31:0] got;
    int gap;
    write_cfg(16'h0002);
    load_word(32'h0000_0003);
    load_word(32'h8000_0007);
    capture(HF, got, gap);
    check(got == with_par(32'h0000_0003), "R9 parity forces bit32", got, 32'h8000_0003);
    capture(HF, got, gap);
    check(got == with_par(32'h8000_0007), "R9 parity clears bit32", got, 32'h0000_0007);
  endtask

  task automatic t_slow;
    logic [31:0] got;
    int gap;
    write_cfg(16'h0001);
    enc_err = 0;
    load_word(32'hDEAD_BEEF);
    capture(HS, got, gap);
    check(got == 32'hDEAD_BEEF, "R10 slow rate cell timing", got, 32'hDEAD_BEEF);
    check(enc_err == 0, "R10 slow rate RZ halves", enc_err, 0);
  endtask

  task automatic t_hold_overflow;
    int hits, gap;
    logic [31:0] got;
    write_cfg(16'h0000);
    tx_en = 1'b0;
    for (int i = 0; i < 8; i++) load_word(32'hA000_0000 + i);
    quiet_for(600, hits);
    check(hits == 0, "R8 hold while disabled", hits, 0);
    check(q_overflow == 0, "R7 no overflow at 8", q_overflow, 0);
    load_word(32'hFFFF_FFFF);
    check(q_overflow == 1, "R7 overflow set", q_overflow, 1);
    @(negedge clk); tx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      capture(HF, got, gap);
      check(got == 32'hA000_0000 + i, "R5 eight-deep FIFO order", got, 32'hA000_0000 + i);
    end
    quiet_for(400, hits);
    check(hits == 0, "R7 ignored word not sent", hits, 0);
    check(q_empty == 1, "R6 empty after drain", q_empty, 1);
    check(q_overflow == 1, "R7 overflow sticky", q_overflow, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_ld_n = 1'b1; lo_ld_n = 1'b1; hi_ld_n = 1'b1;
    tx_en = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_no_cfg;
    t_patterns;
    t_parity;
    t_slow;
    t_hold_overflow;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule